// File: doc/BRIEF.md
# Programmable Dead-Band Generator

This block sits between three raw pulse-width signals and the six pins that drive three half-bridge pairs. For every raw input it produces a high-side output that follows the input and a low-side output that follows its complement. When either output of a pair is about to switch on, the block holds it low for a programmable guard time. An output that is switching off drops at once. Because of this, the two transistors of a leg are never driven together.

All three channels share one 8-bit guard-length value. Each channel has its own 8-bit delay counter and its own enable bit. The counters advance on a clock enable from a power-of-two prescaler, so the same 8-bit value can cover much longer guard times. A polarity stage follows the guard logic and decides, for each pin, whether the pin passes the guarded signal, inverts it, or is forced low or high. That stage is double-buffered: software writes a shadow copy, and the shadow reaches the pins only on a reload strobe. Software can therefore change all six pin states at the same instant, for example at a period boundary.

Top module: `deadband_gen`

## Requirements
- R1: While reset is held and after it is released, all six outputs are low. The guard value, the prescale exponent, the channel enables, the shadow polarity word and the active polarity word all reset to zero.
- R2: Output 2i carries the high side of channel i, and output 2i+1 carries the low side. With pass-through polarity and no guard time, the high side equals the raw input and the low side equals its inverse, one clock after the input is sampled.
- R3: The side that switches off follows the raw edge on the very next clock. The high and low sides of a channel are never high in the same cycle.
- R4: After a raw edge on an enabled channel with guard value D, the side that switches on rises at the first clock at which D prescaler ticks have occurred after the edge clock. With exponent 0 this is D clocks after the clock at which the other side dropped.
- R5: A guard value of 0 adds no delay. Both sides follow the input on the clock after it is sampled.
- R6: A channel whose enable bit is 0 behaves as in R5, whatever the guard value. Enabled channels keep their guard delay.
- R7: If the raw input changes again before the guard time ends, the counter starts over. The side that was waiting never rises early.
- R8: The prescaler is a 7-bit counter that starts at 0 after reset and increments on every clock. With exponent e, a tick occurs in each cycle in which the low e bits of that counter are all ones, so exponent 0 ticks on every clock.
- R9: Each output has a 2-bit polarity code: 00 forces the pin low, 01 drives the inverse of the guarded signal, 10 passes the guarded signal, and 11 forces the pin high. The code for output k sits at bits [2k+1:2k] of the polarity word.
- R10: A write with wr_sel=1 updates only the shadow polarity word and has no effect on the outputs. A reload pulse copies the shadow word, as it stood before that clock, into the active word, and the outputs change on that same clock edge.
- R11: A write with wr_sel=0 loads the configuration word. The guard value is in bits [7:0], the prescale exponent in bits [10:8], and the enables for channels 0 to 2 in bits [13:11]. The new settings take effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_in | input | 3 | Raw pulse-width input, one bit per channel |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the configuration word, 1 the shadow polarity word |
| wr_data | input | 14 | Write data |
| reload | input | 1 | Copies the shadow polarity word into the active word |
| pwm_out | output | 6 | Final outputs; bit 2i is the high side and bit 2i+1 the low side of channel i |

## Verification
A counter that restarts at the wrong time, or that saturates at the wrong value, shows up at the pins as a turn-on edge that is early or late. The error appears within D times 2^e clocks of the raw edge. A bad edge detector shows up as an overlap, or as a missing drop, one clock after the input changes. A mix-up between the shadow and active polarity words changes the pins either at a write that carries no reload, or one clock after a reload. The bench compares every pin in every cycle with a model built from the requirements. It also measures turn-on delays directly in edge-counted cases.

// File: rtl/dbgen_pkg.sv
// Shared types for the dead-band generator.
// Polarity codes select how each output pin treats its guarded signal.
package dbgen_pkg;

    typedef enum logic [1:0] {
        POL_FORCE_LOW  = 2'b00,
        POL_INVERT     = 2'b01,
        POL_PASS       = 2'b10,
        POL_FORCE_HIGH = 2'b11
    } pol_code_e;

    // Apply one polarity code to a guarded signal.
    function automatic logic apply_pol(input logic [1:0] code, input logic din);
        logic r;
        case (pol_code_e'(code))
            POL_FORCE_LOW:  r = 1'b0;
            POL_INVERT:     r = ~din;
            POL_PASS:       r = din;
            default:        r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbgen_prescaler.sv
// Free-running prescaler for the dead-band counters.
// It emits a one-cycle tick every 2^exp_sel clocks: the tick is high when the
// low exp_sel bits of the counter are all ones.
// Assumes exp_sel is at most 2^PSC_W - 1, which the field width guarantees.
module dbgen_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] exp_sel,
    output logic             tick
);
    localparam int PC_W = (1 << PSC_W) - 1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] mask;

    // Count every clock; wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_q + 1'b1;
    end

    // Select the low exp_sel bits and fire when they are all ones.
    always_comb begin
        mask = {PC_W{1'b1}} >> (PC_W - int'(exp_sel));
        tick = ((pc_q & mask) == mask);
    end

    // R8: the counter advances by exactly one per clock.
    p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q != {PC_W{1'b1}}) |=> (pc_q == $past(pc_q) + 1'b1));

endmodule

// File: rtl/dbgen_channel.sv
// One dead-band channel: turns a raw input into a guarded complementary pair.
// Every raw edge restarts the channel counter. The side that is switching off
// drops on the next clock. The side that is switching on waits until the
// counter, which advances on prescaler ticks, reaches the shared guard value.
// Assumes cmp may change at any time; the counter saturates at cmp.
module dbgen_channel #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] cmp,
    input  logic             raw,
    output logic             hi,
    output logic             lo
);
    logic             raw_d;
    logic             flip;
    logic             ready;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;

    // Next counter value and the guarded pair for the next clock.
    always_comb begin
        flip = raw ^ raw_d;
        if (flip)
            cnt_n = '0;
        else if (tick && (cnt_q < cmp))
            cnt_n = cnt_q + 1'b1;
        else
            cnt_n = cnt_q;
        ready = !en || (cnt_n >= cmp);
    end

    // Register the input history, the counter and the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_d <= 1'b0;
            cnt_q <= '0;
            hi    <= 1'b0;
            lo    <= 1'b0;
        end else begin
            raw_d <= raw;
            cnt_q <= cnt_n;
            hi    <= raw & ready;
            lo    <= ~raw & ready;
        end
    end

    // R3: the two sides of a leg never overlap.
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo));

    // R4: with a nonzero guard, the clock after an edge shows both sides low.
    p_blank_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flip && en && (cmp != '0)) |=> (!hi && !lo));

    // R6: a disabled channel is a plain complementary pair.
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((hi == $past(raw)) && (lo == !$past(raw))));

endmodule

// File: rtl/dbgen_polarity.sv
// Final output stage for one pin: applies the active 2-bit polarity code
// to the guarded signal. Purely combinational; the code is held by the top.
module dbgen_polarity
    import dbgen_pkg::*;
(
    input  logic [1:0] code,
    input  logic       din,
    output logic       dout
);
    // Map the code onto the pin level.
    always_comb dout = apply_pol(code, din);

    // R9: forced codes ignore the guarded signal.
    always_comb begin
        if (code == POL_FORCE_HIGH) p_force_high_r9: assert (dout == 1'b1);
    end

endmodule

// File: rtl/deadband_gen.sv
// Dead-band generator top: register write port, shared guard settings,
// one prescaler, NCH guarded channels and a double-buffered polarity stage.
// Config word layout: guard value, then exponent, then channel enables.
// Polarity word: two bits per output, output k at bits [2k+1:2k].
// Assumes wr_en and reload are single-clock strobes in the clk domain.
module deadband_gen #(
    parameter  int NCH   = 3,
    parameter  int CNT_W = 8,
    parameter  int PSC_W = 3,
    localparam int NOUT  = 2 * NCH,
    localparam int POL_W = 2 * NOUT,
    localparam int CFG_USED = CNT_W + PSC_W + NCH,
    localparam int CFG_W = (CFG_USED > POL_W) ? CFG_USED : POL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   raw_in,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             reload,
    output logic [NOUT-1:0]  pwm_out
);
    localparam int EXP_LSB = CNT_W;
    localparam int EN_LSB  = CNT_W + PSC_W;

    logic [CNT_W-1:0] cmp_q;
    logic [PSC_W-1:0] exp_q;
    logic [NCH-1:0]   en_q;
    logic [POL_W-1:0] shadow_q;
    logic [POL_W-1:0] act_q;
    logic             tick;
    logic [NCH-1:0]   hi;
    logic [NCH-1:0]   lo;
    logic [NOUT-1:0]  guarded;

    // Configuration word: guard value, prescale exponent, channel enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            exp_q <= '0;
            en_q  <= '0;
        end else if (wr_en && !wr_sel) begin
            cmp_q <= wr_data[CNT_W-1:0];
            exp_q <= wr_data[EXP_LSB +: PSC_W];
            en_q  <= wr_data[EN_LSB +: NCH];
        end
    end

    // Polarity double buffer: writes land in the shadow, reload moves it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (wr_en && wr_sel) shadow_q <= wr_data[POL_W-1:0];
            if (reload)          act_q    <= shadow_q;
        end
    end

    dbgen_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .exp_sel (exp_q),
        .tick    (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dbgen_channel #(.CNT_W(CNT_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .en    (en_q[g]),
            .cmp   (cmp_q),
            .raw   (raw_in[g]),
            .hi    (hi[g]),
            .lo    (lo[g])
        );
        assign guarded[2*g]   = hi[g];
        assign guarded[2*g+1] = lo[g];
    end

    for (genvar k = 0; k < NOUT; k++) begin : g_pol
        dbgen_polarity u_pol (
            .code (act_q[2*k +: 2]),
            .din  (guarded[k]),
            .dout (pwm_out[k])
        );
    end

    // R10: reload moves the old shadow into the active word.
    p_reload_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (act_q == $past(shadow_q)));

    // R10: without reload the active word holds.
    p_active_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(act_q));

endmodule

// File: tb/sim_deadband_gen.sv
`timescale 1ns/1ps
module sim_deadband_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  raw_in = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [13:0] wr_data = '0;
    logic        reload = 1'b0;
    logic [5:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    deadband_gen u0 (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .reload(reload), .pwm_out(pwm_out)
    );

    // Reference model built from the requirements.
    logic [6:0]  m_pc;
    logic [2:0]  m_rd, m_hi, m_lo, m_en;
    logic [7:0]  m_cnt [3];
    logic [7:0]  m_cmp;
    logic [2:0]  m_exp;
    logic [11:0] m_sh, m_act;

    function automatic logic pol_bit(input logic [1:0] c, input logic x);
        return (c == 2'b00) ? 1'b0 : (c == 2'b01) ? ~x : (c == 2'b10) ? x : 1'b1;
    endfunction

    function automatic logic [5:0] model_out();
        logic [5:0] v;
        for (int k = 0; k < 6; k++)
            v[k] = pol_bit(m_act[2*k +: 2], (k % 2 == 1) ? m_lo[k/2] : m_hi[k/2]);
        return v;
    endfunction

    always @(posedge clk) begin
        logic [7:0] nc;
        logic       tk, rdy;
        if (!rst_n) begin
            m_pc <= '0; m_rd <= '0; m_hi <= '0; m_lo <= '0; m_en <= '0;
            m_cmp <= '0; m_exp <= '0; m_sh <= '0; m_act <= '0;
            for (int i = 0; i < 3; i++) m_cnt[i] <= '0;
        end else begin
            tk = 1'b1;
            for (int b = 0; b < 7; b++) if (b < int'(m_exp) && !m_pc[b]) tk = 1'b0;
            for (int i = 0; i < 3; i++) begin
                nc = m_cnt[i];
                if (raw_in[i] != m_rd[i]) nc = 8'd0;
                else if (tk && nc < m_cmp) nc = nc + 8'd1;
                rdy = !m_en[i] || (nc >= m_cmp);
                m_cnt[i] <= nc;
                m_hi[i]  <= raw_in[i] && rdy;
                m_lo[i]  <= !raw_in[i] && rdy;
            end
            m_rd <= raw_in;
            m_pc <= m_pc + 7'd1;
            if (wr_en && !wr_sel) begin
                m_cmp <= wr_data[7:0]; m_exp <= wr_data[10:8]; m_en <= wr_data[13:11];
            end
            if (wr_en && wr_sel) m_sh <= wr_data[11:0];
            if (reload) m_act <= m_sh;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of all pins with the model (R2 and the rest).
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            logic [5:0] e;
            e = model_out();
            chk(pwm_out == e, "R2 model", pwm_out, e);
        end
    end

    task automatic wr(input bit sel, input logic [13:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_reload();
        @(negedge clk); reload = 1'b1;
        @(negedge clk); reload = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count negedges until pwm_out[bit] is high; also report the partner at n=1.
    task automatic measure(input int b, input int maxn, output int n, output bit partner1);
        n = 0;
        partner1 = 1'b0;
        for (int j = 1; j <= maxn; j++) begin
            @(negedge clk);
            if (j == 1) partner1 = pwm_out[b ^ 1];
            if (pwm_out[b]) begin n = j; break; end
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        bit p;
        bit hi_seen;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(pwm_out == 6'b0, "R1 in reset", pwm_out, 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        settle(3);
        chk(pwm_out == 6'b0, "R1 after reset", pwm_out, 0);

        // R11 layout: guard 4, exponent 0, all enabled.
        wr(1'b0, 14'h3804);
        wr(1'b1, 14'h0AAA);
        settle(3);
        chk(pwm_out == 6'b0, "R10 shadow write no effect", pwm_out, 0);
        do_reload();
        settle(8);
        chk(pwm_out == 6'b101010, "R2 idle pass-through", pwm_out, 6'b101010);

        raw_in[0] = 1'b1;
        measure(0, 20, n, p);
        chk(p == 1'b0, "R3 low side drops at once", p, 0);
        chk(n == 5, "R11/R4 guard 4 turn-on", n, 5);

        wr(1'b0, 14'h3800);
        settle(3);
        raw_in[1] = 1'b1;
        measure(2, 20, n, p);
        chk(n == 1, "R5 zero guard", n, 1);
        chk(p == 1'b0, "R3 partner low", p, 0);

        wr(1'b0, 14'h2806);
        settle(10);
        raw_in[1] = 1'b0;
        measure(3, 20, n, p);
        chk(n == 1, "R6 disabled channel", n, 1);
        raw_in[0] = 1'b0;
        measure(1, 20, n, p);
        chk(n == 7, "R6 enabled channel keeps guard", n, 7);

        // R7: retoggle inside the guard window.
        wr(1'b0, 14'h3806);
        settle(10);
        hi_seen = 1'b0;
        raw_in[2] = 1'b1;
        repeat (3) begin @(negedge clk); hi_seen |= pwm_out[4]; end
        raw_in[2] = 1'b0;
        n = 0;
        for (int j = 1; j <= 20; j++) begin
            @(negedge clk);
            hi_seen |= pwm_out[4];
            if (pwm_out[5] && n == 0) n = j;
        end
        chk(hi_seen == 1'b0, "R7 no early turn-on", hi_seen, 0);
        chk(n == 7, "R7 restart then guard", n, 7);

        // R8: exponent 2, guard 3.
        wr(1'b0, 14'h3A03);
        settle(20);
        raw_in[0] = 1'b1;
        measure(0, 40, n, p);
        chk(n >= 10 && n <= 13, "R8 prescaled guard", n, 11);

        // R9: out0 forced high, out1 inverted, others forced low.
        wr(1'b1, 14'h0007);
        do_reload();
        settle(2);
        chk(pwm_out[0] == 1'b1, "R9 force high", pwm_out[0], 1);
        chk(pwm_out[1] == 1'b1, "R9 invert", pwm_out[1], 1);
        chk(pwm_out[5:2] == 4'b0, "R9 force low", pwm_out[5:2], 0);

        // Random phase against the model.
        for (int i = 0; i < 4000; i++) begin
            int r;
            @(negedge clk);
            wr_en = 1'b0;
            reload = 1'b0;
            r = $urandom % 100;
            if (r < 10) begin
                int c;
                c = $urandom % 3;
                raw_in[c] = ~raw_in[c];
            end else if (r < 13) begin
                wr_en = 1'b1; wr_sel = 1'b0;
                wr_data = {3'($urandom % 8), 3'($urandom % 3), 8'($urandom % 8)};
            end else if (r < 16) begin
                wr_en = 1'b1; wr_sel = 1'b1;
                wr_data = {2'b00, 12'($urandom)};
            end else if (r < 19) begin
                reload = 1'b1;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        reload = 1'b0;
        settle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule